// File: doc/BRIEF.md
# GPIO Input Conditioning and Interrupt Detector

This block sits between the raw general-purpose pad inputs and the interrupt fabric of a chip. Each pad bit first crosses a two-flop synchronizer. A stability filter then admits a new level into the sampled value only after the synchronized bit has held that level on two consecutive clock edges, so single-cycle glitches are discarded. The sampled vector is exported, and the block watches it for four independent conditions on every pin: a rising edge, a falling edge, a high level and a low level.

Each condition has its own enable mask and its own sticky pending vector. A pending bit is set when its condition is seen with the enable bit at 1. It stays set until the register interface pulses a 1 at that bit position on the matching clear input. The enable masks and the clear strobes come from an external register block. Pending state is tracked for every pin. Only the lowest `IRQ_COUNT` pins drive interrupt lines, and each line is the OR of the four pending bits of its pin.

Top module: `gpio_irq_sense`

## Requirements
- R1: A change on `padIn[i]` reaches `sampledVal[i]` only if the synchronized bit holds the new level on two consecutive edges. A level held from before rising edge 1 appears after rising edge 4. A pulse lasting one cycle never changes `sampledVal`. A pulse lasting two cycles is accepted.
- R2: When `sampledVal[i]` goes from 0 to 1 and `riseEn[i]` is 1, `risePend[i]` becomes 1 on the next rising edge.
- R3: When `sampledVal[i]` goes from 1 to 0 and `fallEn[i]` is 1, `fallPend[i]` becomes 1 on the next rising edge.
- R4: On every edge where `sampledVal[i]` is 1 and `highEn[i]` is 1, `highPend[i]` is set. On every edge where `sampledVal[i]` is 0 and `lowEn[i]` is 1, `lowPend[i]` is set.
- R5: The four kinds are independent per pin. Any mix may be enabled, and a kind whose enable bit is 0 never sets its pending bit.
- R6: A pending bit keeps its value until a 1 is presented at its bit position on the matching clear input (`riseClr`, `fallClr`, `highClr`, `lowClr`) at a rising edge.
- R7: If an edge event and a clear for the same pending bit occur on the same edge, the bit stays 1, so the new event is kept.
- R8: A clear of a level pending bit takes effect even while its condition and enable are still active. The bit reads 0 for one cycle and is set again on the following edge.
- R9: `irqOut[i]` for i below `IRQ_COUNT` is the OR of the rise, fall, high and low pending bits of pin i. Pins at or above `IRQ_COUNT` keep pending state but drive no interrupt line.
- R10: `rstN` is a synchronous, active-low reset. While it is low at a rising edge, the synchronizer, filter, sampled value, edge history and all pending bits clear to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| padIn | input | PIN_COUNT | Raw pad input levels, asynchronous |
| riseEn | input | PIN_COUNT | Rising-edge enable mask |
| fallEn | input | PIN_COUNT | Falling-edge enable mask |
| highEn | input | PIN_COUNT | High-level enable mask |
| lowEn | input | PIN_COUNT | Low-level enable mask |
| riseClr | input | PIN_COUNT | Write-1-to-clear strobe for rise pending bits |
| fallClr | input | PIN_COUNT | Write-1-to-clear strobe for fall pending bits |
| highClr | input | PIN_COUNT | Write-1-to-clear strobe for high pending bits |
| lowClr | input | PIN_COUNT | Write-1-to-clear strobe for low pending bits |
| sampledVal | output | PIN_COUNT | Filtered, synchronized input value |
| risePend | output | PIN_COUNT | Rise pending bits |
| fallPend | output | PIN_COUNT | Fall pending bits |
| highPend | output | PIN_COUNT | High pending bits |
| lowPend | output | PIN_COUNT | Low pending bits |
| irqOut | output | IRQ_COUNT | Per-pin interrupt lines for the low pins |

## Verification
Event detection and the clear strobe can both act on one pending bit in the same cycle. The bench forces this twice. In the first case a second rising edge is made to reach the sampled value in exactly the cycle where `riseClr` is pulsed, and the rise pending bit must read 1 afterwards. In the second case `highClr` is pulsed while the high level is still present, and the high pending bit must read 0 for one cycle and then 1 again.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Default number of synchronizer flops ahead of the stability filter.
  localparam int SyncDepthDefault = 2;

  // Per-pin strobes handed from control to the datapath.
  // The set and clear priorities are already resolved by the control.
  typedef struct packed {
    logic setRise;
    logic setFall;
    logic setHigh;
    logic setLow;
    logic clrRise;
    logic clrFall;
    logic clrHigh;
    logic clrLow;
  } pinStrobe_t;

endpackage

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT   = 22,
  parameter int SYNC_STAGES = SyncDepthDefault
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PIN_COUNT-1:0]   padIn,
  input  pinStrobe_t [PIN_COUNT-1:0] strobes,
  output logic [PIN_COUNT-1:0]   sampledVal,
  output logic [PIN_COUNT-1:0]   risePend,
  output logic [PIN_COUNT-1:0]   fallPend,
  output logic [PIN_COUNT-1:0]   highPend,
  output logic [PIN_COUNT-1:0]   lowPend
);

  localparam int LastStage = SYNC_STAGES - 1;

  // Synchronizer chain: stage 0 samples the pads.
  logic [PIN_COUNT-1:0] syncChain [SYNC_STAGES];
  logic [PIN_COUNT-1:0] syncOut;
  logic [PIN_COUNT-1:0] holdPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign syncOut = syncChain[LastStage];

  // One cycle of history for the stability filter.
  always_ff @(posedge clk) begin
    if (!rstN) holdPrev <= '0;
    else       holdPrev <= syncOut;
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    // Accept a level only when two consecutive synchronized samples agree.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sampledVal[p] <= 1'b0;
      end else if (syncOut[p] == holdPrev[p]) begin
        sampledVal[p] <= syncOut[p];
      end
    end

    // Sticky pending bits.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        risePend[p] <= 1'b0;
        fallPend[p] <= 1'b0;
        highPend[p] <= 1'b0;
        lowPend[p]  <= 1'b0;
      end else begin
        risePend[p] <= (risePend[p] & ~strobes[p].clrRise) | strobes[p].setRise;
        fallPend[p] <= (fallPend[p] & ~strobes[p].clrFall) | strobes[p].setFall;
        highPend[p] <= (highPend[p] & ~strobes[p].clrHigh) | strobes[p].setHigh;
        lowPend[p]  <= (lowPend[p]  & ~strobes[p].clrLow)  | strobes[p].setLow;
      end
    end
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 22
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PIN_COUNT-1:0]   sampledVal,
  input  logic [PIN_COUNT-1:0]   riseEn,
  input  logic [PIN_COUNT-1:0]   fallEn,
  input  logic [PIN_COUNT-1:0]   highEn,
  input  logic [PIN_COUNT-1:0]   lowEn,
  input  logic [PIN_COUNT-1:0]   riseClr,
  input  logic [PIN_COUNT-1:0]   fallClr,
  input  logic [PIN_COUNT-1:0]   highClr,
  input  logic [PIN_COUNT-1:0]   lowClr,
  output pinStrobe_t [PIN_COUNT-1:0] strobes
);

  // Previous sampled value, the reference for edge detection.
  logic [PIN_COUNT-1:0] prevSampled;

  always_ff @(posedge clk) begin
    if (!rstN) prevSampled <= '0;
    else       prevSampled <= sampledVal;
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic riseHit;
    logic fallHit;
    logic highHit;
    logic lowHit;

    always_comb begin
      riseHit = sampledVal[p] & ~prevSampled[p] & riseEn[p];
      fallHit = ~sampledVal[p] & prevSampled[p] & fallEn[p];
      highHit = sampledVal[p] & highEn[p];
      lowHit  = ~sampledVal[p] & lowEn[p];

      // An edge event wins over a coincident clear, so it is not lost.
      strobes[p].setRise = riseHit;
      strobes[p].clrRise = riseClr[p] & ~riseHit;
      strobes[p].setFall = fallHit;
      strobes[p].clrFall = fallClr[p] & ~fallHit;

      // A level clear wins for one cycle. The level sets the bit again afterwards.
      strobes[p].setHigh = highHit & ~highClr[p];
      strobes[p].clrHigh = highClr[p];
      strobes[p].setLow  = lowHit & ~lowClr[p];
      strobes[p].clrLow  = lowClr[p];
    end
  end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 22,
  parameter int IRQ_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic [PIN_COUNT-1:0] riseEn,
  input  logic [PIN_COUNT-1:0] fallEn,
  input  logic [PIN_COUNT-1:0] highEn,
  input  logic [PIN_COUNT-1:0] lowEn,
  input  logic [PIN_COUNT-1:0] riseClr,
  input  logic [PIN_COUNT-1:0] fallClr,
  input  logic [PIN_COUNT-1:0] highClr,
  input  logic [PIN_COUNT-1:0] lowClr,
  output logic [PIN_COUNT-1:0] sampledVal,
  output logic [PIN_COUNT-1:0] risePend,
  output logic [PIN_COUNT-1:0] fallPend,
  output logic [PIN_COUNT-1:0] highPend,
  output logic [PIN_COUNT-1:0] lowPend,
  output logic [IRQ_COUNT-1:0] irqOut
);

  pinStrobe_t [PIN_COUNT-1:0] strobes;

  gpio_irq_ctrl #(
    .PIN_COUNT(PIN_COUNT)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampledVal(sampledVal),
    .riseEn    (riseEn),
    .fallEn    (fallEn),
    .highEn    (highEn),
    .lowEn     (lowEn),
    .riseClr   (riseClr),
    .fallClr   (fallClr),
    .highClr   (highClr),
    .lowClr    (lowClr),
    .strobes   (strobes)
  );

  gpio_irq_datapath #(
    .PIN_COUNT  (PIN_COUNT),
    .SYNC_STAGES(SyncDepthDefault)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .padIn     (padIn),
    .strobes   (strobes),
    .sampledVal(sampledVal),
    .risePend  (risePend),
    .fallPend  (fallPend),
    .highPend  (highPend),
    .lowPend   (lowPend)
  );

  // Only the low pins are exported as interrupt lines.
  for (genvar i = 0; i < IRQ_COUNT; i++) begin : g_irq
    assign irqOut[i] = risePend[i] | fallPend[i] | highPend[i] | lowPend[i];
  end

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
  parameter int PIN_COUNT = 22
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [PIN_COUNT-1:0] padIn,
  input logic [PIN_COUNT-1:0] riseEn,
  input logic [PIN_COUNT-1:0] fallEn,
  input logic [PIN_COUNT-1:0] highEn,
  input logic [PIN_COUNT-1:0] lowEn,
  input logic [PIN_COUNT-1:0] riseClr,
  input logic [PIN_COUNT-1:0] highClr,
  input logic [PIN_COUNT-1:0] lowClr,
  input logic [PIN_COUNT-1:0] sampledVal,
  input logic [PIN_COUNT-1:0] risePend,
  input logic [PIN_COUNT-1:0] fallPend,
  input logic [PIN_COUNT-1:0] highPend,
  input logic [PIN_COUNT-1:0] lowPend
);

  // Edges seen since reset release, saturating, to keep $past inside that window.
  logic [2:0] upCnt;

  always_ff @(posedge clk) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 3'd7) upCnt <= upCnt + 3'd1;
  end

  // R1: a bit of the sampled value changes only to a level that the pad held on two consecutive samples.
  p_filter_r1: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 3'd6) |->
      ((((sampledVal ^ $past(sampledVal)) & ($past(padIn, 3) ^ $past(padIn, 4))) == '0) &&
       (((sampledVal ^ $past(sampledVal)) & (sampledVal ^ $past(padIn, 3))) == '0)));

  // R2: an enabled rise of the sampled value leaves its pending bit set.
  p_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 3'd3) |->
      ((($past(sampledVal) & ~$past(sampledVal, 2) & $past(riseEn)) & ~risePend) == '0));

  // R3: an enabled fall of the sampled value leaves its pending bit set.
  p_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 3'd3) |->
      (((~$past(sampledVal) & $past(sampledVal, 2) & $past(fallEn)) & ~fallPend) == '0));

  // R4: an enabled high level with no clear sets the high pending bit.
  p_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 3'd1) |-> (($past(sampledVal & highEn & ~highClr) & ~highPend) == '0));

  // R4: an enabled low level with no clear sets the low pending bit.
  p_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 3'd1) |-> (($past(~sampledVal & lowEn & ~lowClr) & ~lowPend) == '0));

  // R6: a rise pending bit can only drop after a clear at its position.
  p_sticky_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 3'd1) |-> ((($past(risePend) & ~$past(riseClr)) & ~risePend) == '0));

  // R6: a high pending bit can only drop after a clear at its position.
  p_sticky_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 3'd1) |-> ((($past(highPend) & ~$past(highClr)) & ~highPend) == '0));

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(
  .PIN_COUNT(PIN_COUNT)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .padIn     (padIn),
  .riseEn    (riseEn),
  .fallEn    (fallEn),
  .highEn    (highEn),
  .lowEn     (lowEn),
  .riseClr   (riseClr),
  .highClr   (highClr),
  .lowClr    (lowClr),
  .sampledVal(sampledVal),
  .risePend  (risePend),
  .fallPend  (fallPend),
  .highPend  (highPend),
  .lowPend   (lowPend)
);

// File: tb/test_gpio_irq_sense.sv
`timescale 1ns/1ps
module test_gpio_irq_sense;

  localparam int Pins = 22;
  localparam int Irqs = 16;

  logic            clk = 1'b0;
  logic            rstN;
  logic [Pins-1:0] padIn, riseEn, fallEn, highEn, lowEn;
  logic [Pins-1:0] riseClr, fallClr, highClr, lowClr;
  logic [Pins-1:0] sampledVal, risePend, fallPend, highPend, lowPend;
  logic [Irqs-1:0] irqOut;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_sense #(.PIN_COUNT(Pins), .IRQ_COUNT(Irqs)) i_gpio_irq_sense (
    .clk(clk), .rstN(rstN), .padIn(padIn),
    .riseEn(riseEn), .fallEn(fallEn), .highEn(highEn), .lowEn(lowEn),
    .riseClr(riseClr), .fallClr(fallClr), .highClr(highClr), .lowClr(lowClr),
    .sampledVal(sampledVal), .risePend(risePend), .fallPend(fallPend),
    .highPend(highPend), .lowPend(lowPend), .irqOut(irqOut)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drops all enables, lets pads settle and clears every pending bit.
  task automatic clearAll();
    riseEn = '0; fallEn = '0; highEn = '0; lowEn = '0;
    waitCycles(6);
    riseClr = '1; fallClr = '1; highClr = '1; lowClr = '1;
    waitCycles(1);
    riseClr = '0; fallClr = '0; highClr = '0; lowClr = '0;
  endtask

  task automatic testResetState();
    check(sampledVal, 0, "R10 sampled after reset");
    check(risePend | fallPend | highPend | lowPend, 0, "R10 pending after reset");
    check(irqOut, 0, "R10 irq after reset");
  endtask

  task automatic testFilter();
    padIn[0] = 1'b1;
    waitCycles(3);
    check(sampledVal[0], 0, "R1 not yet accepted after 3 edges");
    waitCycles(1);
    check(sampledVal[0], 1, "R1 accepted after 4 edges");
  endtask

  task automatic testGlitch();
    clearAll();
    riseEn[1] = 1'b1;
    padIn[1] = 1'b1;
    waitCycles(1);
    padIn[1] = 1'b0;
    waitCycles(8);
    check(sampledVal[1], 0, "R1 one-cycle glitch rejected");
    check(risePend[1], 0, "R1 glitch raises no rise event");
    padIn[1] = 1'b1;
    waitCycles(2);
    padIn[1] = 1'b0;
    waitCycles(8);
    check(risePend[1], 1, "R1 two-cycle pulse accepted");
  endtask

  task automatic testRise();
    clearAll();
    riseEn[2] = 1'b1;
    padIn[2] = 1'b1;
    waitCycles(4);
    check(risePend[2], 0, "R2 pending not before sampled edge");
    waitCycles(1);
    check(risePend[2], 1, "R2 rise pending set");
    check(irqOut[2], 1, "R9 irq follows rise pending");
    padIn[2] = 1'b0;
    waitCycles(6);
    check(risePend[2], 1, "R6 pending sticky without clear");
    riseClr[2] = 1'b1;
    waitCycles(1);
    riseClr[2] = 1'b0;
    check(risePend[2], 0, "R6 clear strobe drops pending");
    check(irqOut[2], 0, "R9 irq drops with pending");
  endtask

  task automatic testFall();
    clearAll();
    fallEn[3] = 1'b1;
    padIn[3] = 1'b1;
    waitCycles(6);
    check(fallPend[3], 0, "R3 no fall on rising input");
    padIn[3] = 1'b0;
    waitCycles(4);
    check(fallPend[3], 0, "R3 pending not before sampled edge");
    waitCycles(1);
    check(fallPend[3], 1, "R3 fall pending set");
    check(risePend[3], 0, "R5 rise stays clear when disabled");
  endtask

  task automatic testLevel();
    clearAll();
    highEn[4] = 1'b1;
    waitCycles(2);
    check(highPend[4], 0, "R4 no high pending while low");
    padIn[4] = 1'b1;
    waitCycles(5);
    check(highPend[4], 1, "R4 high pending set");
    lowEn[5] = 1'b1;
    waitCycles(1);
    check(lowPend[5], 1, "R4 low pending set on enable");
    highClr[4] = 1'b1;
    waitCycles(1);
    highClr[4] = 1'b0;
    check(highPend[4], 0, "R8 level clear takes effect");
    waitCycles(1);
    check(highPend[4], 1, "R8 level pending sets again");
  endtask

  task automatic testMulti();
    clearAll();
    riseEn[7] = 1'b1; fallEn[7] = 1'b1; highEn[7] = 1'b1; lowEn[7] = 1'b1;
    fallEn[8] = 1'b1;
    waitCycles(1);
    check(lowPend[7], 1, "R5 low kind alongside others");
    check({risePend[7], fallPend[7], highPend[7]}, 0, "R5 other kinds idle");
    padIn[7] = 1'b1;
    padIn[8] = 1'b1;
    waitCycles(5);
    check({risePend[7], fallPend[7], highPend[7], lowPend[7]}, 4'b1011, "R5 rise high low set, fall clear");
    check({risePend[8], fallPend[8], highPend[8], lowPend[8]}, 0, "R5 pin with only fall enabled stays clear");
    check(irqOut[8:7], 2'b01, "R9 irq per pin");
  endtask

  task automatic testCollide();
    clearAll();
    riseEn[6] = 1'b1;
    padIn[6] = 1'b1;
    waitCycles(6);
    check(risePend[6], 1, "R2 first rise pending");
    padIn[6] = 1'b0;
    waitCycles(6);
    padIn[6] = 1'b1;
    waitCycles(4);
    riseClr[6] = 1'b1;
    waitCycles(1);
    riseClr[6] = 1'b0;
    check(risePend[6], 1, "R7 new edge wins over clear");
    riseClr[6] = 1'b1;
    waitCycles(1);
    riseClr[6] = 1'b0;
    check(risePend[6], 0, "R7 later clear drops pending");
  endtask

  task automatic testUpper();
    clearAll();
    riseEn[20] = 1'b1;
    padIn[20] = 1'b1;
    waitCycles(5);
    check(risePend[20], 1, "R9 upper pin keeps pending");
    check(irqOut, 0, "R9 upper pin drives no irq");
    riseEn[15] = 1'b1;
    padIn[15] = 1'b1;
    waitCycles(5);
    check(irqOut, 16'h8000, "R9 highest exported pin");
  endtask

  task automatic testResetAgain();
    rstN = 1'b0;
    waitCycles(1);
    check(sampledVal, 0, "R10 sampled cleared by reset");
    check(risePend | fallPend | highPend | lowPend, 0, "R10 pending cleared by reset");
    rstN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0;
    padIn = '0; riseEn = '0; fallEn = '0; highEn = '0; lowEn = '0;
    riseClr = '0; fallClr = '0; highClr = '0; lowClr = '0;
    waitCycles(3);
    testResetState();
    rstN = 1'b1;
    testFilter();
    testGlitch();
    testRise();
    testFall();
    testLevel();
    testMulti();
    testCollide();
    testUpper();
    testResetAgain();
    waitCycles(2);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule